// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frame data from a shared 16-bit buffer memory to a byte-wide transmit stream. The host builds a ring of 8-byte descriptors in that memory, where each descriptor points at one buffer. It hands a descriptor over by setting its ownership flag, then pulses the transmit-demand input. The engine starts at its current ring index. It fetches each descriptor and checks it. It streams the buffer bytes out on a valid/ready interface, marking the first and last bytes of each frame. It then clears the ownership flag, writes the descriptor back and moves to the next slot.

One frame may span several descriptors. A start flag opens the frame and an end flag closes it. The scan stops quietly at the first descriptor the host still owns, or at one without the mandatory marker nibble. It stops with the error flag raised on a length out of range, on a continuation buffer with no frame open, or when it comes all the way round the ring. A completed frame raises the transmit-done flag.

The memory port has a single-cycle read latency. The byte order inside a memory word is chosen by a parameter, and is little-endian by default.

Top module: `txring_engine`

## Requirements
- R1: After reset the engine is idle. It makes no memory access, holds tx_valid low, holds both flags low and sets the ring index to 0.
- R2: Descriptor slot i occupies the four 16-bit words at byte addresses ring_base + 8*i + {0,2,4,6}. The buffer's 24-bit byte address is {word1[7:0], word0}. Its length is 4096 minus word2[11:0]. The bytes are sent in ascending address order. With the default little-endian setting, the even byte address sits in bits 7:0 of a memory word.
- R3: A descriptor whose word1 bit 15 (ownership) is 0 ends the scan. No byte is sent, nothing is written and the error flag is not raised.
- R4: A descriptor whose word2[15:12] is not 1111 ends the scan quietly and is left unwritten.
- R5: Lengths from 12 to 1900 inclusive are accepted. Any other length ends the scan with the error flag set, no bytes sent and the descriptor unwritten.
- R6: word1 bit 9 is the start flag and bit 8 is the end flag. tx_first is high on the first byte of a buffer that has the start flag. tx_last is high on the last byte of a buffer that has the end flag. Buffers without either flag continue the open frame.
- R7: A buffer without the start flag that arrives while no frame is open ends the scan with the error flag set, and no bytes are sent.
- R8: A start-flagged buffer that arrives while a frame is open abandons the partial frame. A new frame begins with tx_first, and no error is raised.
- R9: After a buffer is sent, word1 is rewritten with bit 15 cleared and every other bit unchanged. Words 2 and 3 are rewritten unchanged and word 0 is never written. A read and a write never occur in the same cycle.
- R10: The transmit-done flag rises after a descriptor carrying the end flag has been written back. Both flags hold their value until the next scan starts, and the start of a scan clears them.
- R11: The ring index advances by one per consumed descriptor and wraps to 0 at 2^ring_code entries. It persists between scans, so a new scan resumes where the last one stopped.
- R12: If the index returns to the slot where the scan began, the scan ends with the error flag set.
- R13: While tx_valid is high and tx_ready is low, tx_data, tx_first and tx_last hold their values. No memory access happens while a byte is being offered.
- R14: A demand pulse that arrives during a scan is remembered, and it starts another scan once the current one ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 24 | Byte address of descriptor slot 0 (even) |
| ring_code | input | 3 | Ring size code; the ring holds 2^code slots |
| tx_demand | input | 1 | One-cycle transmit-demand pulse |
| mem_addr | output | 24 | Memory byte address; bit 0 is not decoded by the memory |
| mem_rd | output | 1 | Read strobe; data arrives on mem_rdata next cycle |
| mem_we | output | 1 | Write strobe for mem_wdata |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | tx_data is valid |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_done_irq | output | 1 | A frame completed during this scan |
| err_flag | output | 1 | The scan ended on a fault |

## Verification
On every cycle the assertions check the stream handshake hold and the rule that the memory bus is quiet while a byte is offered. They also check that reads and writes never overlap, that the transmit-done flag only rises right after a write-back, and that the error flag never rises while a byte is offered. Only the bench scenarios can show the descriptor decoding, the byte order, and the stop conditions with their chosen flag values. The same holds for chained and restarted frames, for the index persisting and wrapping between scans, and for a demand pulse remembered mid-scan. The bench checks these through the stream contents and the descriptor memory after each scan.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int ADDR_W   = 24;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 7;
    localparam int LEN_W    = 13;
    localparam int OWN_BIT  = 15;
    localparam int STP_BIT  = 9;
    localparam int ENP_BIT  = 8;
    localparam int DESC_WORDS = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_CHK,
        ST_BRD, ST_BCAP, ST_BOUT, ST_WB1, ST_WB2, ST_WB3
    } state_t;

    typedef enum logic [2:0] {
        V_GO, V_NOTOWN, V_BADMARK, V_BADLEN, V_ORPHAN
    } verdict_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              stp;
        logic              enp;
    } buf_t;

    function automatic logic [IDX_W-1:0] ring_mask(input logic [2:0] code);
        logic [IDX_W:0] full;
        full = (IDX_W+1)'(1) << code;
        return IDX_W'(full - (IDX_W+1)'(1));
    endfunction

    function automatic logic [LEN_W-1:0] buf_len(input logic [11:0] neg);
        return LEN_W'(4096) - {1'b0, neg};
    endfunction

endpackage

// File: rtl/txring_index.sv
module txring_index
    import txring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       code,
    input  logic             mark,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             wrap_hit
);
    logic [IDX_W-1:0] idx_q, start_q, next_idx;

    assign next_idx = (idx_q + IDX_W'(1)) & ring_mask(code);
    assign wrap_hit = (next_idx == start_q);
    assign idx      = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            start_q <= '0;
        end else begin
            if (mark) start_q <= idx_q;
            if (step) idx_q   <= next_idx;
        end
    end
endmodule

// File: rtl/txring_desc_check.sv
module txring_desc_check
    import txring_pkg::*;
#(
    parameter int MIN_LEN = 12,
    parameter int MAX_LEN = 1900
)(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    input  logic              frame_open,
    output verdict_t          verdict,
    output buf_t              info
);
    localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

    always_comb begin
        info.addr = {w1[7:0], w0};
        info.len  = buf_len(w2[11:0]);
        info.stp  = w1[STP_BIT];
        info.enp  = w1[ENP_BIT];
        // Priority order matters: ownership, marker, length, chaining.
        if (!w1[OWN_BIT])
            verdict = V_NOTOWN;
        else if (w2[15:12] != 4'hF)
            verdict = V_BADMARK;
        else if (info.len < LO || info.len > HI)
            verdict = V_BADLEN;
        else if (!info.stp && !frame_open)
            verdict = V_ORPHAN;
        else
            verdict = V_GO;
    end
endmodule

// File: rtl/txring_bytelane.sv
module txring_bytelane
    import txring_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
)(
    input  logic [WORD_W-1:0] word,
    input  logic              odd,
    output logic [BYTE_W-1:0] lane
);
    generate
        if (BIG_ENDIAN) begin : g_be
            assign lane = odd ? word[7:0] : word[15:8];
        end else begin : g_le
            assign lane = odd ? word[15:8] : word[7:0];
        end
    endgenerate
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0,
    parameter int MIN_LEN    = 12,
    parameter int MAX_LEN    = 1900
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [2:0]        ring_code,
    input  logic              tx_demand,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              tx_done_irq,
    output logic              err_flag
);
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;

    state_t            st_q;
    logic [WORD_W-1:0] dw_q [DESC_WORDS];
    buf_t              cur_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] byte_q;
    logic              open_q, pend_q, irq_q, err_q;

    logic [IDX_W-1:0]  idx;
    logic              wrap_hit;
    logic              mark, step;
    verdict_t          verdict;
    buf_t              info;
    logic [BYTE_W-1:0] lane;
    logic [ADDR_W-1:0] dbase;
    logic              last_byte;

    assign mark      = (st_q == ST_IDLE) && pend_q;
    assign step      = (st_q == ST_WB3);
    assign dbase     = ring_base + ADDR_W'({idx, 3'b000});
    assign last_byte = (cnt_q == cur_q.len - LEN_W'(1));

    txring_index u_index (
        .clk(clk), .rst(rst), .code(ring_code), .mark(mark), .step(step),
        .idx(idx), .wrap_hit(wrap_hit)
    );

    txring_desc_check #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_check (
        .w0(dw_q[0]), .w1(dw_q[1]), .w2(dw_q[2]), .frame_open(open_q),
        .verdict(verdict), .info(info)
    );

    txring_bytelane #(.BIG_ENDIAN(BIG_ENDIAN)) u_lane (
        .word(mem_rdata), .odd(cur_q.addr[0]), .lane(lane)
    );

    // Memory port: driven purely from the state.
    always_comb begin
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dbase;
        mem_wdata = '0;
        unique case (st_q)
            ST_RD0: mem_rd = 1'b1;
            ST_RD1: begin mem_rd = 1'b1; mem_addr = dbase + ADDR_W'(2); end
            ST_RD2: begin mem_rd = 1'b1; mem_addr = dbase + ADDR_W'(4); end
            ST_RD3: begin mem_rd = 1'b1; mem_addr = dbase + ADDR_W'(6); end
            ST_BRD: begin mem_rd = 1'b1; mem_addr = cur_q.addr; end
            ST_WB1: begin
                mem_we    = 1'b1;
                mem_addr  = dbase + ADDR_W'(2);
                mem_wdata = dw_q[1] & ~OWN_MASK;
            end
            ST_WB2: begin mem_we = 1'b1; mem_addr = dbase + ADDR_W'(4); mem_wdata = dw_q[2]; end
            ST_WB3: begin mem_we = 1'b1; mem_addr = dbase + ADDR_W'(6); mem_wdata = dw_q[3]; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            cnt_q  <= '0;
            byte_q <= '0;
            open_q <= 1'b0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
            for (int k = 0; k < DESC_WORDS; k++) dw_q[k] <= '0;
        end else begin
            if (tx_demand) pend_q <= 1'b1;
            unique case (st_q)
                ST_IDLE: if (pend_q) begin
                    pend_q <= tx_demand;
                    irq_q  <= 1'b0;
                    err_q  <= 1'b0;
                    st_q   <= ST_RD0;
                end
                ST_RD0: st_q <= ST_RD1;
                ST_RD1: begin dw_q[0] <= mem_rdata; st_q <= ST_RD2; end
                ST_RD2: begin dw_q[1] <= mem_rdata; st_q <= ST_RD3; end
                ST_RD3: begin dw_q[2] <= mem_rdata; st_q <= ST_CHK; end
                ST_CHK: begin
                    dw_q[3] <= mem_rdata;
                    unique case (verdict)
                        V_GO: begin
                            cur_q  <= info;
                            cnt_q  <= '0;
                            open_q <= 1'b1;
                            st_q   <= ST_BRD;
                        end
                        V_BADLEN, V_ORPHAN: begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
                ST_BRD:  st_q <= ST_BCAP;
                ST_BCAP: begin byte_q <= lane; st_q <= ST_BOUT; end
                ST_BOUT: if (tx_ready) begin
                    if (last_byte) begin
                        st_q <= ST_WB1;
                    end else begin
                        cnt_q      <= cnt_q + LEN_W'(1);
                        cur_q.addr <= cur_q.addr + ADDR_W'(1);
                        st_q       <= ST_BRD;
                    end
                end
                ST_WB1: st_q <= ST_WB2;
                ST_WB2: st_q <= ST_WB3;
                ST_WB3: begin
                    if (cur_q.enp) begin
                        open_q <= 1'b0;
                        irq_q  <= 1'b1;
                    end
                    if (wrap_hit) begin
                        err_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end else begin
                        st_q <= ST_RD0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign tx_valid    = (st_q == ST_BOUT);
    assign tx_data     = byte_q;
    assign tx_first    = tx_valid && cur_q.stp && (cnt_q == '0);
    assign tx_last     = tx_valid && cur_q.enp && last_byte;
    assign tx_done_irq = irq_q;
    assign err_flag    = err_q;

endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       mem_rd,
    input logic       mem_we,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_first,
    input logic       tx_last,
    input logic       tx_ready,
    input logic       tx_done_irq,
    input logic       err_flag
);
    assert_rw_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));

    assert_hold_byte_R13: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)
                                 && $stable(tx_first) && $stable(tx_last));

    assert_bus_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_rd && !mem_we);

    assert_irq_after_wb_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done_irq) |-> $past(mem_we));

    assert_err_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> !tx_valid);
endmodule

bind txring_engine txring_engine_chk u_chk (.*);

// File: tb/txring_engine_test.sv
`timescale 1ns/1ps
module txring_engine_test;

    localparam int RB_WORD = 16'h0080;   // ring base byte 0x100

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] ring_base = 24'h000100;
    logic [2:0]  ring_code = 3'd1;
    logic        tx_demand = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_first, tx_last;
    logic        tx_ready;
    logic        tx_done_irq, err_flag;

    logic        tog = 1'b0;
    logic        stall = 1'b0;
    assign tx_ready = stall ? tog : 1'b1;

    always #2.5 clk = ~clk;

    txring_engine uut (
        .clk(clk), .rst(rst), .ring_base(ring_base), .ring_code(ring_code),
        .tx_demand(tx_demand), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first),
        .tx_last(tx_last), .tx_ready(tx_ready), .tx_done_irq(tx_done_irq),
        .err_flag(err_flag)
    );

    logic [15:0] mem [0:4095];
    always @(posedge clk) begin
        tog <= ~tog;
        if (mem_we) mem[mem_addr[12:1]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[12:1]];
    end

    logic [7:0] rx_b [0:4095];
    logic       rx_f [0:4095];
    logic       rx_l [0:4095];
    logic [7:0] ex_b [0:4095];
    int n_rx = 0, n_ex = 0;
    int nchk = 0, nerr = 0;

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (n_rx < 4096) begin
                rx_b[n_rx] = tx_data;
                rx_f[n_rx] = tx_first;
                rx_l[n_rx] = tx_last;
            end
            n_rx = n_rx + 1;
        end
    end

    typedef struct packed {
        logic [15:0] w1f;
        logic [15:0] w2;
        logic [23:0] addr;
        logic [15:0] nbytes;
        logic        err;
        logic        irq;
        logic        own_after;
    } row_t;

    // Single-descriptor scenarios: flags, word2, buffer, expected results.
    localparam row_t ROWS [8] = '{
        '{16'h8300, 16'hFFF4, 24'h000401,   12, 1'b0, 1'b1, 1'b0},
        '{16'h8300, 16'hF894, 24'h000400, 1900, 1'b0, 1'b1, 1'b0},
        '{16'h8300, 16'hFFF5, 24'h000400,    0, 1'b1, 1'b0, 1'b1},
        '{16'h8300, 16'hF893, 24'h000400,    0, 1'b1, 1'b0, 1'b1},
        '{16'h0300, 16'hFFF4, 24'h000400,    0, 1'b0, 1'b0, 1'b0},
        '{16'h8300, 16'hEFF4, 24'h000400,    0, 1'b0, 1'b0, 1'b1},
        '{16'h8000, 16'hFFF4, 24'h000400,    0, 1'b1, 1'b0, 1'b1},
        '{16'h8200, 16'hFFEC, 24'h000403,   20, 1'b0, 1'b0, 1'b0}
    };

    function automatic string row_req(input int i);
        case (i)
            0, 7:    return "R2";
            1, 2, 3: return "R5";
            4:       return "R3";
            5:       return "R4";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A ^ 8'(a >> 8);
    endfunction

    function automatic logic [15:0] lenw(input int n);
        return 16'hF000 | (16'(4096 - n) & 16'h0FFF);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int w = 0; w < 4096; w++) mem[w] = {pat(2*w + 1), pat(2*w)};
    endtask

    task automatic put_desc(input int idx, input logic [15:0] flags,
                            input int baddr, input logic [15:0] w2);
        int wb;
        wb = RB_WORD + idx*4;
        mem[wb]     = 16'(baddr);
        mem[wb + 1] = flags | {8'h00, 8'(baddr >> 16)};
        mem[wb + 2] = w2;
        mem[wb + 3] = 16'h1234 ^ 16'(idx);
    endtask

    function automatic int own_of(input int idx);
        return int'(mem[RB_WORD + idx*4 + 1][15]);
    endfunction

    task automatic expect_buf(input int baddr, input int len);
        for (int k = 0; k < len; k++) begin
            ex_b[n_ex] = pat(baddr + k);
            n_ex++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_rx = 0;
        n_ex = 0;
    endtask

    task automatic wait_quiet();
        int q;
        q = 0;
        while (q < 20) begin
            @(negedge clk);
            if (mem_rd || mem_we || tx_valid) q = 0;
            else q++;
        end
    endtask

    task automatic pulse_demand();
        @(negedge clk) tx_demand = 1'b1;
        @(negedge clk) tx_demand = 1'b0;
    endtask

    task automatic run_scan(input logic [2:0] code);
        ring_code = code;
        pulse_demand();
        wait_quiet();
    endtask

    task automatic check_stream(input string req);
        int bad;
        bad = 0;
        check(req, "byte count", n_rx, n_ex);
        for (int k = 0; k < n_rx && k < n_ex; k++)
            if (rx_b[k] !== ex_b[k]) bad++;
        check(req, "byte mismatches", bad, 0);
    endtask

    function automatic int count_first();
        int c;
        c = 0;
        for (int k = 0; k < n_rx; k++) if (rx_f[k]) c++;
        return c;
    endfunction

    function automatic int count_last();
        int c;
        c = 0;
        for (int k = 0; k < n_rx; k++) if (rx_l[k]) c++;
        return c;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1", "tx_valid", int'(tx_valid), 0);
        check("R1", "irq", int'(tx_done_irq), 0);
        check("R1", "err", int'(err_flag), 0);
        check("R1", "mem access", int'(mem_rd | mem_we), 0);

        // Table of single-descriptor scenarios
        for (int i = 0; i < 8; i++) begin
            do_reset();
            fill_mem();
            put_desc(0, ROWS[i].w1f, int'(ROWS[i].addr), ROWS[i].w2);
            put_desc(1, 16'h0300, 24'h000800, lenw(12));
            expect_buf(int'(ROWS[i].addr), int'(ROWS[i].nbytes));
            run_scan(3'd1);
            check_stream(row_req(i));
            check(row_req(i), "err", int'(err_flag), int'(ROWS[i].err));
            check(row_req(i), "irq R10", int'(tx_done_irq), int'(ROWS[i].irq));
            check(row_req(i), "own after", own_of(0), int'(ROWS[i].own_after));
            check("R6", "first count", count_first(),
                  (ROWS[i].nbytes != 0 && ROWS[i].w1f[9]) ? 1 : 0);
            check("R6", "last count", count_last(),
                  (ROWS[i].nbytes != 0 && ROWS[i].w1f[8]) ? 1 : 0);
            if (ROWS[i].nbytes != 0) begin
                check("R9", "word1 low bits", int'(mem[RB_WORD + 1]),
                      int'(ROWS[i].w1f & 16'h7FFF));
                check("R9", "word2", int'(mem[RB_WORD + 2]), int'(ROWS[i].w2));
                check("R9", "word3", int'(mem[RB_WORD + 3]), 16'h1234);
                check("R9", "word0", int'(mem[RB_WORD]), int'(ROWS[i].addr & 24'hFFFF));
            end
        end

        // R6 / R13: chained frame with back-pressure
        do_reset();
        fill_mem();
        stall = 1'b1;
        put_desc(0, 16'h8200, 24'h000400, lenw(12));
        put_desc(1, 16'h8000, 24'h000500, lenw(13));
        put_desc(2, 16'h8100, 24'h000600, lenw(14));
        put_desc(3, 16'h0300, 24'h000700, lenw(12));
        expect_buf(24'h000400, 12);
        expect_buf(24'h000500, 13);
        expect_buf(24'h000600, 14);
        run_scan(3'd2);
        check_stream("R13");
        check("R6", "first count", count_first(), 1);
        check("R6", "first at 0", int'(rx_f[0]), 1);
        check("R6", "last count", count_last(), 1);
        check("R6", "last at 38", int'(rx_l[38]), 1);
        check("R6", "err", int'(err_flag), 0);
        check("R9", "own d0", own_of(0), 0);
        check("R9", "own d1", own_of(1), 0);
        check("R9", "own d2", own_of(2), 0);
        check("R3", "d3 untouched", int'(mem[RB_WORD + 13]), 16'h0300);
        repeat (50) @(negedge clk);
        check("R10", "irq sticky", int'(tx_done_irq), 1);
        stall = 1'b0;

        // R11: index persists at 3, wraps to 0
        n_rx = 0;
        n_ex = 0;
        put_desc(3, 16'h8300, 24'h000900, lenw(12));
        put_desc(0, 16'h8300, 24'h000980, lenw(12));
        put_desc(1, 16'h0300, 24'h000A00, lenw(12));
        expect_buf(24'h000900, 12);
        expect_buf(24'h000980, 12);
        run_scan(3'd2);
        check_stream("R11");
        check("R11", "own d3", own_of(3), 0);
        check("R11", "own d0", own_of(0), 0);
        check("R11", "err", int'(err_flag), 0);

        // R8: start flag while frame open
        do_reset();
        fill_mem();
        put_desc(0, 16'h8200, 24'h000400, lenw(12));
        put_desc(1, 16'h8300, 24'h000480, lenw(13));
        put_desc(2, 16'h0300, 24'h000500, lenw(12));
        expect_buf(24'h000400, 12);
        expect_buf(24'h000480, 13);
        run_scan(3'd2);
        check_stream("R8");
        check("R8", "first count", count_first(), 2);
        check("R8", "first at 12", int'(rx_f[12]), 1);
        check("R8", "last at 24", int'(rx_l[24]), 1);
        check("R8", "err", int'(err_flag), 0);
        check("R8", "irq", int'(tx_done_irq), 1);

        // R12: one-slot ring comes straight back to its start
        do_reset();
        fill_mem();
        put_desc(0, 16'h8300, 24'h000400, lenw(12));
        expect_buf(24'h000400, 12);
        run_scan(3'd0);
        check_stream("R12");
        check("R12", "err", int'(err_flag), 1);
        check("R12", "irq", int'(tx_done_irq), 1);
        check("R12", "own d0", own_of(0), 0);

        // R14: second demand during scan starts a second scan, which clears irq
        do_reset();
        fill_mem();
        put_desc(0, 16'h8300, 24'h000400, lenw(200));
        put_desc(1, 16'h0300, 24'h000600, lenw(12));
        expect_buf(24'h000400, 200);
        ring_code = 3'd1;
        pulse_demand();
        repeat (40) @(negedge clk);
        pulse_demand();
        wait_quiet();
        check_stream("R14");
        check("R14", "irq cleared by rescan", int'(tx_done_irq), 0);
        check("R14", "err", int'(err_flag), 0);

        finish_run();
    end

endmodule